// File: doc/BRIEF.md
# Indirect Dword Register Window

This block implements an eight-byte capability window in configuration space. Through it, software reaches a larger memory-mapped register set one dword at a time. Software writes a select byte to pick a dword, at byte address select × 4 in the register set. It then reads the data dword of the window to see that register, or writes the data dword to change it.

The window occupies two consecutive configuration dwords starting at dword index `WIN_DW`. In the first dword, bits 23:16 hold the select byte. Bits 26 and 27 are two read-only status bits that read as zero. The other bits of that dword belong to surrounding logic and read as zero from this block. The second dword is the data field. It is a registered mirror of the selected register-set dword.

After a write that lands in the window, the block does one of two things:
- If the write touched the data dword, the block first forwards the whole 32-bit data value to the register set as one write. It then reloads the mirror from the register set.
- If the write touched only the first dword, the block only reloads the mirror.

While this refresh is in progress, `cfg_ready` is low and further accesses are held off. The register-set port reads combinationally. The block itself bounds every access to the `RS_BYTES` bytes that exist. A dword wholly past the end is neither written nor read and mirrors as zero. A dword that straddles the end uses only its lanes that lie below the end.

Top module: `cfg_dword_window`

## Requirements
- R1: After reset the select byte, both status bits and the data field read as 0, and `cfg_ready` is high.
- R2: A read of window dword 0 returns {8'h00, select, 16'h0000}. A read of window dword 1 returns the data mirror.
- R3: The select byte is written from wdata[23:16] when be[2] is set. Lanes 0, 1 and 3 of dword 0, including the status bits 26 and 27, ignore writes and keep reading 0.
- R4: A write to window dword 1 updates the data bytes whose byte enables are set. One cycle later the block issues a single `rs_wr` of the full 32-bit data at `rs_addr` = select × 4.
- R5: After any window write with a non-zero byte enable, the mirror is reloaded from the register set at the current select. Register-set bits that ignore writes show their own value afterwards.
- R6: A write to dword 0 alone still refreshes the mirror, so the next data read returns the newly selected dword.
- R7: After an accepted data-dword write, `cfg_ready` is low for exactly 2 cycles. After a dword-0-only write, it is low for exactly 1 cycle. A read requested in that time waits and returns the refreshed value.
- R8: A write outside the two window dwords, or a window write with all byte enables clear, causes no `rs_wr`, no `rs_rd` and no change to the window. A read outside the window returns 0.
- R9: When select × 4 ≥ `RS_BYTES`, the block issues no register-set write or read, and the mirror reloads as 0.
- R10: When the selected dword straddles `RS_BYTES`, `rs_be` sets only the lanes below the end. Those lanes alone are written, and the lanes above the end mirror as 0.
- R11: An accepted read gives `cfg_rvalid` high in the next cycle, with data as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write request |
| cfg_rd | input | 1 | Configuration read request |
| cfg_addr | input | DW_AW | Configuration dword index |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_ready | output | 1 | High when a request is accepted this cycle |
| cfg_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| cfg_rdata | output | 32 | Read data, zero outside the window |
| rs_wr | output | 1 | Register-set write strobe |
| rs_rd | output | 1 | Register-set read strobe (data sampled same cycle) |
| rs_addr | output | SEL_W+2 | Register-set byte address, select × 4 |
| rs_be | output | 4 | Register-set lane enables, limited to implemented bytes |
| rs_wdata | output | 32 | Register-set write data |
| rs_rdata | input | 32 | Register-set read data, combinational |

## Verification
The bench aims at these corner cases:
- A read-only register-set dword. A block that never reloads after forwarding would echo the written value instead of the register's own.
- A write to the status lane alone. This must still refresh, which catches a design that refreshes only on select changes.
- The dword straddling the end and a dword past the end. A design that gets these wrong strobes lanes beyond the end, or lets garbage lanes into the mirror.
- Exact stall lengths, and accesses just outside the window. These expose a window decoded one dword too wide, or a refresh that is started spuriously.

// File: rtl/cfg_dword_window.sv
module cfg_dword_window #(
  parameter int               DW_AW    = 6,
  parameter logic [DW_AW-1:0] WIN_DW   = 6'h10,
  parameter int               RS_BYTES = 130,
  localparam int              SEL_W    = 8,
  localparam int              RS_AW    = SEL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [DW_AW-1:0] cfg_addr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic             cfg_ready,
  output logic             cfg_rvalid,
  output logic [31:0]      cfg_rdata,
  output logic             rs_wr,
  output logic             rs_rd,
  output logic [RS_AW-1:0] rs_addr,
  output logic [3:0]       rs_be,
  output logic [31:0]      rs_wdata,
  input  logic [31:0]      rs_rdata
);

  localparam logic [DW_AW-1:0] DAT_DW = WIN_DW + DW_AW'(1);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_LOAD} st_t;

  st_t              st;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      data_q;
  logic [3:0]       lane_ok;
  logic [31:0]      lane_mask;

  wire hit_ctl = cfg_addr == WIN_DW;
  wire hit_dat = cfg_addr == DAT_DW;
  wire acc_wr  = cfg_wr && cfg_ready;
  wire acc_rd  = cfg_rd && cfg_ready;
  wire win_wr  = acc_wr && (hit_ctl || hit_dat) && (cfg_be != 4'h0);
  wire [RS_AW:0] base_ext = {1'b0, sel_q, 2'b00};

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_ok[g] = (base_ext + (RS_AW+1)'(g)) < (RS_AW+1)'(RS_BYTES);
    assign lane_mask[8*g +: 8] = {8{lane_ok[g]}};
  end

  assign cfg_ready = st == S_IDLE;
  assign rs_addr   = base_ext[RS_AW-1:0];
  assign rs_be     = lane_ok;
  assign rs_wdata  = data_q;
  assign rs_wr     = (st == S_FWD)  && (lane_ok != 4'h0);
  assign rs_rd     = (st == S_LOAD) && (lane_ok != 4'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sel_q      <= '0;
      data_q     <= '0;
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= acc_rd;
      if (acc_rd) begin
        if (hit_ctl)      cfg_rdata <= {8'h00, sel_q, 16'h0000};
        else if (hit_dat) cfg_rdata <= data_q;
        else              cfg_rdata <= '0;
      end
      case (st)
        S_IDLE: if (win_wr) begin
          if (hit_ctl && cfg_be[2]) sel_q <= cfg_wdata[23:16];
          if (hit_dat) begin
            for (int b = 0; b < 4; b++)
              if (cfg_be[b]) data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
          end
          st <= hit_dat ? S_FWD : S_LOAD;
        end
        S_FWD:  st <= S_LOAD;
        S_LOAD: begin
          data_q <= rs_rdata & lane_mask;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dword_window_chk.sv
module cfg_dword_window_chk #(
  parameter int               DW_AW    = 6,
  parameter logic [DW_AW-1:0] WIN_DW   = 6'h10,
  parameter int               RS_BYTES = 130
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [DW_AW-1:0] cfg_addr,
  input logic [3:0]       cfg_be,
  input logic             cfg_ready,
  input logic             cfg_rvalid,
  input logic             rs_wr,
  input logic             rs_rd,
  input logic [9:0]       rs_addr,
  input logic [3:0]       rs_be
);

  wire in_win = (cfg_addr == WIN_DW) || (cfg_addr == WIN_DW + DW_AW'(1));

  // R4
  fwd_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_wr |=> rs_rd);

  // R7
  stall_during_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_wr |-> !cfg_ready);

  // R6
  refresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ready && in_win && cfg_be != 4'h0) |=> !cfg_ready);

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ready && !in_win) |=> (!rs_wr && !rs_rd && cfg_ready));

  // R9
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_wr || rs_rd) |-> ({1'b0, rs_addr} < 11'(RS_BYTES)));

  // R10
  straddle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rs_wr || rs_rd) && ({1'b0, rs_addr} + 11'd4 > 11'(RS_BYTES))) |-> (rs_be != 4'hf));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_ready) |=> cfg_rvalid);

endmodule

bind cfg_dword_window cfg_dword_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_ready(cfg_ready),
  .cfg_rvalid(cfg_rvalid), .rs_wr(rs_wr), .rs_rd(rs_rd),
  .rs_addr(rs_addr), .rs_be(rs_be)
);

// File: tb/cfg_dword_window_tb.sv
`timescale 1ns/1ps
module cfg_dword_window_tb;
  localparam int RSB = 130;
  localparam logic [5:0] CTL = 6'h10;
  localparam logic [5:0] DAT = 6'h11;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [5:0] cfg_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic cfg_ready, cfg_rvalid, rs_wr, rs_rd;
  logic [31:0] cfg_rdata, rs_wdata, rs_rdata;
  logic [9:0] rs_addr;
  logic [3:0] rs_be;

  always #5 clk = ~clk;

  cfg_dword_window u_dut (.*);

  logic [7:0] mem [RSB];
  int gmem [RSB];
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic int pat(int a); return (a * 37 + 11) & 8'hff; endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      if (int'(rs_addr) + i < RSB) rs_rdata[8*i +: 8] = mem[int'(rs_addr) + i];
      else rs_rdata[8*i +: 8] = 8'hEE;
    end
  end

  always @(posedge clk) if (rs_wr)
    for (int i = 0; i < 4; i++)
      if (rs_be[i] && int'(rs_addr) + i >= 4 && int'(rs_addr) + i < RSB)
        mem[int'(rs_addr) + i] <= rs_wdata[8*i +: 8];

  // behavioural reference
  int m_sel, m_pend; bit m_rvalid; logic [31:0] m_data, m_rdata;

  function automatic logic [3:0] lanes(int s);
    for (int i = 0; i < 4; i++) lanes[i] = (s * 4 + i) < RSB;
  endfunction

  function automatic logic [31:0] gread(int s);
    for (int i = 0; i < 4; i++)
      gread[8*i +: 8] = (s * 4 + i < RSB) ? 8'(gmem[s * 4 + i]) : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_pend = 0; m_data = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      m_rvalid = 0;
      if (m_pend == 2) begin
        for (int i = 0; i < 4; i++)
          if (m_sel * 4 + i >= 4 && m_sel * 4 + i < RSB) gmem[m_sel * 4 + i] = int'(m_data[8*i +: 8]);
        m_pend = 1;
      end else if (m_pend == 1) begin
        m_data = gread(m_sel); m_pend = 0;
      end else begin
        if (cfg_rd) begin
          m_rvalid = 1;
          m_rdata = (cfg_addr == CTL) ? {8'h00, 8'(m_sel), 16'h0} : (cfg_addr == DAT) ? m_data : 32'h0;
        end
        if (cfg_wr && (cfg_addr == CTL || cfg_addr == DAT) && cfg_be != 0) begin
          if (cfg_addr == CTL && cfg_be[2]) m_sel = int'(cfg_wdata[23:16]);
          if (cfg_addr == DAT)
            for (int i = 0; i < 4; i++) if (cfg_be[i]) m_data[8*i +: 8] = cfg_wdata[8*i +: 8];
          m_pend = (cfg_addr == DAT) ? 2 : 1;
        end
      end
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [3:0] ln; ln = lanes(m_sel);
    cmp("R7", "cfg_ready", 32'(cfg_ready), 32'(m_pend == 0));
    cmp("R11", "cfg_rvalid", 32'(cfg_rvalid), 32'(m_rvalid));
    if (m_rvalid) cmp("R2", "cfg_rdata", cfg_rdata, m_rdata);
    cmp("R4", "rs_wr", 32'(rs_wr), 32'(m_pend == 2 && ln != 0));
    cmp("R5", "rs_rd", 32'(rs_rd), 32'(m_pend == 1 && ln != 0));
    if (rs_wr || rs_rd) begin
      cmp("R10", "rs_be", 32'(rs_be), 32'(ln));
      cmp("R4", "rs_addr", 32'(rs_addr), 32'(m_sel * 4));
    end
    if (rs_wr) cmp("R4", "rs_wdata", rs_wdata, m_data);
  end

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d, output int low);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    low = 0;
    while (!cfg_ready) begin low++; @(negedge clk); end
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    cmp(req, "rvalid", 32'(cfg_rvalid), 32'h1);
    cmp(req, "read", cfg_rdata, exp);
  endtask

  function automatic logic [31:0] pdw(int s);
    for (int i = 0; i < 4; i++) pdw[8*i +: 8] = 8'(pat(s * 4 + i));
  endfunction

  initial begin
    int low;
    for (int a = 0; a < RSB; a++) begin mem[a] = 8'(pat(a)); gmem[a] = pat(a); end
    repeat (3) @(negedge clk);
    // R1
    cmp("R1", "ready in reset", 32'(cfg_ready), 32'h1);
    rst_n = 1;
    rd_chk(CTL, 32'h0, "R1");
    rd_chk(DAT, 32'h0, "R1");
    // R6 select-only write, one stall cycle
    wr(CTL, 4'b0100, 32'h0003_0000, low);
    cmp("R7", "stall after select write", 32'(low), 32'd1);
    rd_chk(DAT, pdw(3), "R6");
    rd_chk(CTL, 32'h0003_0000, "R2");
    // R3 all lanes of dword 0 written; only select takes
    wr(CTL, 4'b1111, 32'hCF05_ABCD, low);
    rd_chk(CTL, 32'h0005_0000, "R3");
    rd_chk(DAT, pdw(5), "R3");
    // R4 full data write, two stall cycles, read waits then sees value
    wr(DAT, 4'hf, 32'h1234_5678, low);
    cmp("R7", "stall after data write", 32'(low), 32'd2);
    rd_chk(DAT, 32'h1234_5678, "R4");
    // R4 partial lane write
    wr(DAT, 4'b0010, 32'h0000_AB00, low);
    rd_chk(DAT, 32'h1234_AB78, "R4");
    // R5 behind-the-back change picked up by status-lane-only write
    mem[22] = 8'h5A; gmem[22] = 8'h5A;
    wr(CTL, 4'b1000, 32'hFF00_0000, low);
    cmp("R5", "stall after status-lane write", 32'(low), 32'd1);
    rd_chk(DAT, 32'h125A_AB78, "R5");
    rd_chk(CTL, 32'h0005_0000, "R3");
    // R5 read-only dword 0 shows its own value
    wr(CTL, 4'b0100, 32'h0000_0000, low);
    wr(DAT, 4'hf, 32'hDEAD_BEEF, low);
    rd_chk(DAT, pdw(0), "R5");
    // R8 outside the window and empty byte enables
    wr(6'h12, 4'hf, 32'h0BAD_0BAD, low);
    cmp("R8", "stall after outside write", 32'(low), 32'd0);
    wr(6'h0F, 4'hf, 32'h0BAD_0BAD, low);
    wr(DAT, 4'h0, 32'h0BAD_0BAD, low);
    cmp("R8", "stall after empty write", 32'(low), 32'd0);
    rd_chk(DAT, pdw(0), "R8");
    rd_chk(6'h12, 32'h0, "R8");
    // R10 straddling dword at 128
    wr(CTL, 4'b0100, 32'h0020_0000, low);
    rd_chk(DAT, {16'h0, pdw(32)[15:0]}, "R10");
    wr(DAT, 4'hf, 32'hAABB_CCDD, low);
    rd_chk(DAT, 32'h0000_CCDD, "R10");
    cmp("R10", "mem[128]", 32'(mem[128]), 32'hDD);
    cmp("R10", "mem[129]", 32'(mem[129]), 32'hCC);
    // R9 beyond end
    wr(CTL, 4'b0100, 32'h0028_0000, low);
    wr(DAT, 4'hf, 32'h1111_2222, low);
    rd_chk(DAT, 32'h0, "R9");
    // R4 forwarded contents against golden
    for (int a = 0; a < RSB; a++) cmp("R4", "register set byte", 32'(mem[a]), 32'(gmem[a]));
    cmp("R4", "dword 5", {mem[23], mem[22], mem[21], mem[20]}, 32'h125A_AB78);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule